// File: doc/BRIEF.md
# Hashed Inverted Page Table Translator

This block maps a (process ID, virtual page number) pair to a physical frame number. Its table has one entry per physical frame, so its size depends on physical memory and not on how many processes exist. The low part of the table holds the home rows, which are addressed directly by hashing the page number. The high part is a pool of overflow slots. A home row that receives more than one mapping links them into a chain through these slots. Each entry holds a valid flag, the page and process tags, the frame number, an allocated flag and an optional link to the next entry.

A lookup request arrives with a valid/ready handshake. The block then walks the chain for that request's home row, reading one entry per clock cycle. When the walk ends it pulses a response carrying hit/miss and the frame number. A separate maintenance port lets a controller insert or invalidate mappings. This port uses the same walk engine and the same one-operation-at-a-time discipline. The block does not choose which mapping to evict and does not handle faults.

Top module: `ipt_xlate`

## Requirements
- R1: After synchronous reset every entry is invalid, unallocated and unlinked, both ready outputs are high in the idle state, and every lookup then misses.
- R2: Entry indices 0 to NUM_HOME-1 are home rows and the remaining indices are overflow slots. Every walk begins at home row (page number mod NUM_HOME).
- R3: A lookup hits only on a valid entry whose stored process ID and page number both equal the request. On a hit, the response carries that entry's frame number.
- R4: A walk examines one entry per cycle. A lookup response or a maintenance done pulse appears exactly k cycles after the accepting clock edge, where k is the number of entries examined. An insert that appends a slot takes one cycle more. Response and done are single-cycle pulses.
- R5: A non-matching entry lets the walk follow its link only while fewer than MAX_VISIT entries have been examined. An invalid entry that still carries a link is passed over. A walk ends as a miss, with frame output 0, at an entry that has no link or when the limit is reached.
- R6: Only one operation is in flight at a time. Both ready outputs stay low from acceptance until the cycle in which the response or done pulse is high. When both ports request in the same idle cycle, the maintenance request is taken first and lookup ready is held low.
- R7: An insert writes the mapping into the first invalid entry on its home row's chain, starting at the home row. An existing link on that entry is kept.
- R8: If every entry on the chain is valid, an insert takes the lowest-numbered unallocated overflow slot, writes the mapping there with no link, and links the chain's last entry to it.
- R9: An insert raises the error output together with its done pulse, and changes nothing, when no overflow slot is free or when the chain already holds MAX_VISIT entries.
- R10: An invalidate clears only the valid flag of the first matching valid entry on the chain. Entries behind it stay reachable. An invalidate that finds no match changes nothing and reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request can be taken this cycle |
| lk_pid | input | PID_W | Process ID of the lookup |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| rsp_valid | output | 1 | One-cycle lookup result pulse |
| rsp_hit | output | 1 | Lookup found a mapping |
| rsp_frame | output | FRAME_W | Frame number of the hit, 0 on a miss |
| mt_valid | input | 1 | Maintenance request present |
| mt_ready | output | 1 | Maintenance request can be taken this cycle |
| mt_op | input | 1 | 0 = insert, 1 = invalidate |
| mt_pid | input | PID_W | Process ID of the mapping |
| mt_vpn | input | VPN_W | Virtual page number of the mapping |
| mt_frame | input | FRAME_W | Frame number to store (insert only) |
| mt_done | output | 1 | One-cycle completion pulse for maintenance |
| mt_err | output | 1 | Insert failed, valid with mt_done |

## Verification
A corrupted link or allocated flag does not show up right away. It shows up when a later lookup on the same home row returns the wrong hit flag, or when its response arrives a different number of cycles after acceptance than the chain length predicts. For this reason, every response is checked both for its value and for its exact latency. A wrong tombstone or a wrong slot choice shows up on the next insert to that row, in its done latency or its error flag. The directed sequence drives chains up to the visit limit and exhausts the overflow pool. Random mixed operations on a few colliding pages keep reusing chains after invalidation.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int PID_W   = 8;
    localparam int VPN_W   = 12;
    localparam int FRAME_W = 6;
    localparam int IDX_W   = 3;
    localparam int ENTRIES = 1 << IDX_W;

    typedef logic [PID_W-1:0]   pid_t;
    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        logic   valid;
        logic   used;
        logic   chained;
        idx_t   next;
        pid_t   pid;
        vpn_t   vpn;
        frame_t frame;
    } ipt_entry_t;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_INVAL  = 2'd2
    } ipt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_LINK = 2'd2
    } ipt_state_e;

    function automatic idx_t home_of(input vpn_t v, input int rows);
        return idx_t'(v % vpn_t'(rows));
    endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table
    import ipt_pkg::*;
#(
    parameter int NUM_HOME = 4,
    localparam int NUM_OVF = ENTRIES - NUM_HOME
) (
    input  logic               clk,
    input  logic               rst,
    input  idx_t               rd_idx,
    output ipt_entry_t         rd_entry,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  ipt_entry_t         wr_entry,
    output logic [NUM_OVF-1:0] ovf_used
);

    ipt_entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = mem[rd_idx];

    for (genvar g = 0; g < NUM_OVF; g++) begin : g_used
        assign ovf_used[g] = mem[NUM_HOME + g].used;
    end

    AST_LINK_TO_OVF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_entry.chained) |-> (int'(wr_entry.next) >= NUM_HOME)); // R8

    AST_NEW_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) >= NUM_HOME && !mem[wr_idx].used)
            |-> (wr_entry.valid && !wr_entry.chained)); // R8

endmodule

// File: rtl/ipt_free_pick.sv
module ipt_free_pick
    import ipt_pkg::*;
#(
    parameter int NUM_HOME = 4,
    localparam int NUM_OVF = ENTRIES - NUM_HOME
) (
    input  logic [NUM_OVF-1:0] ovf_used,
    output logic               found,
    output idx_t               slot
);

    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = NUM_OVF - 1; i >= 0; i--) begin
            if (!ovf_used[i]) begin
                found = 1'b1;
                slot  = idx_t'(NUM_HOME + i);
            end
        end
    end

endmodule

// File: rtl/ipt_ctrl.sv
module ipt_ctrl
    import ipt_pkg::*;
#(
    parameter int NUM_HOME  = 4,
    parameter int MAX_VISIT = 8,
    localparam int CNT_W    = $clog2(MAX_VISIT + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lk_valid,
    output logic       lk_ready,
    input  pid_t       lk_pid,
    input  vpn_t       lk_vpn,
    output logic       rsp_valid,
    output logic       rsp_hit,
    output frame_t     rsp_frame,
    input  logic       mt_valid,
    output logic       mt_ready,
    input  logic       mt_op,
    input  pid_t       mt_pid,
    input  vpn_t       mt_vpn,
    input  frame_t     mt_frame,
    output logic       mt_done,
    output logic       mt_err,
    output idx_t       rd_idx,
    input  ipt_entry_t rd_entry,
    output logic       wr_en,
    output idx_t       wr_idx,
    output ipt_entry_t wr_entry,
    input  logic       free_ok,
    input  idx_t       free_idx
);

    localparam logic [CNT_W-1:0] VMAX = CNT_W'(MAX_VISIT);

    ipt_state_e        state;
    ipt_op_e           k_op;
    pid_t              k_pid;
    vpn_t              k_vpn;
    frame_t            k_frame;
    idx_t              cur;
    idx_t              slot;
    logic [CNT_W-1:0]  vcnt;

    ipt_entry_t e;
    logic       tag_hit;
    logic       more;
    logic       room;

    assign rd_idx   = cur;
    assign lk_ready = (state == ST_IDLE) && !mt_valid;
    assign mt_ready = (state == ST_IDLE);

    always_comb begin
        e        = rd_entry;
        tag_hit  = e.valid && (e.pid == k_pid) && (e.vpn == k_vpn);
        more     = e.chained && (vcnt < VMAX);
        room     = !e.chained && (vcnt < VMAX) && free_ok;
        wr_en    = 1'b0;
        wr_idx   = cur;
        wr_entry = e;
        if (state == ST_WALK) begin
            case (k_op)
                OP_INSERT: begin
                    if (!e.valid) begin
                        wr_en          = 1'b1;
                        wr_entry.valid = 1'b1;
                        wr_entry.used  = 1'b1;
                        wr_entry.pid   = k_pid;
                        wr_entry.vpn   = k_vpn;
                        wr_entry.frame = k_frame;
                    end else if (!more && room) begin
                        wr_en            = 1'b1;
                        wr_idx           = free_idx;
                        wr_entry.valid   = 1'b1;
                        wr_entry.used    = 1'b1;
                        wr_entry.chained = 1'b0;
                        wr_entry.next    = '0;
                        wr_entry.pid     = k_pid;
                        wr_entry.vpn     = k_vpn;
                        wr_entry.frame   = k_frame;
                    end
                end
                OP_INVAL: begin
                    if (tag_hit) begin
                        wr_en          = 1'b1;
                        wr_entry.valid = 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (state == ST_LINK) begin
            wr_en            = 1'b1;
            wr_entry.chained = 1'b1;
            wr_entry.next    = slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            k_op      <= OP_LOOKUP;
            k_pid     <= '0;
            k_vpn     <= '0;
            k_frame   <= '0;
            cur       <= '0;
            slot      <= '0;
            vcnt      <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            mt_done   <= 1'b0;
            mt_err    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            mt_done   <= 1'b0;
            mt_err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (mt_valid) begin
                        k_op    <= mt_op ? OP_INVAL : OP_INSERT;
                        k_pid   <= mt_pid;
                        k_vpn   <= mt_vpn;
                        k_frame <= mt_frame;
                        cur     <= home_of(mt_vpn, NUM_HOME);
                        vcnt    <= CNT_W'(1);
                        state   <= ST_WALK;
                    end else if (lk_valid) begin
                        k_op    <= OP_LOOKUP;
                        k_pid   <= lk_pid;
                        k_vpn   <= lk_vpn;
                        cur     <= home_of(lk_vpn, NUM_HOME);
                        vcnt    <= CNT_W'(1);
                        state   <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    case (k_op)
                        OP_LOOKUP: begin
                            if (tag_hit) begin
                                rsp_valid <= 1'b1;
                                rsp_hit   <= 1'b1;
                                rsp_frame <= e.frame;
                                state     <= ST_IDLE;
                            end else if (more) begin
                                cur  <= e.next;
                                vcnt <= vcnt + 1'b1;
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_hit   <= 1'b0;
                                rsp_frame <= '0;
                                state     <= ST_IDLE;
                            end
                        end
                        OP_INSERT: begin
                            if (!e.valid) begin
                                mt_done <= 1'b1;
                                state   <= ST_IDLE;
                            end else if (more) begin
                                cur  <= e.next;
                                vcnt <= vcnt + 1'b1;
                            end else if (room) begin
                                slot  <= free_idx;
                                state <= ST_LINK;
                            end else begin
                                mt_done <= 1'b1;
                                mt_err  <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end
                        default: begin
                            if (tag_hit) begin
                                mt_done <= 1'b1;
                                state   <= ST_IDLE;
                            end else if (more) begin
                                cur  <= e.next;
                                vcnt <= vcnt + 1'b1;
                            end else begin
                                mt_done <= 1'b1;
                                state   <= ST_IDLE;
                            end
                        end
                    endcase
                end
                ST_LINK: begin
                    mt_done <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mt_done |=> !mt_done); // R4

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> (!lk_ready && !mt_ready)); // R6

    AST_MAINT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && mt_valid && lk_valid) |=> (k_op != OP_LOOKUP)); // R6

    AST_VISIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |-> (vcnt >= CNT_W'(1) && vcnt <= VMAX)); // R5

    AST_HOME_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (mt_valid || lk_valid)) |=> (int'(cur) < NUM_HOME)); // R2

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        mt_err |-> mt_done); // R9

    AST_MISS_ZERO_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_frame == '0)); // R5

endmodule

// File: rtl/ipt_xlate.sv
module ipt_xlate
    import ipt_pkg::*;
#(
    parameter int NUM_HOME  = 4,
    parameter int MAX_VISIT = 8,
    localparam int NUM_OVF  = ENTRIES - NUM_HOME
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    output logic               lk_ready,
    input  logic [PID_W-1:0]   lk_pid,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [FRAME_W-1:0] rsp_frame,
    input  logic               mt_valid,
    output logic               mt_ready,
    input  logic               mt_op,
    input  logic [PID_W-1:0]   mt_pid,
    input  logic [VPN_W-1:0]   mt_vpn,
    input  logic [FRAME_W-1:0] mt_frame,
    output logic               mt_done,
    output logic               mt_err
);

    idx_t               rd_idx;
    ipt_entry_t         rd_entry;
    logic               wr_en;
    idx_t               wr_idx;
    ipt_entry_t         wr_entry;
    logic [NUM_OVF-1:0] ovf_used;
    logic               free_ok;
    idx_t               free_idx;

    ipt_table #(.NUM_HOME(NUM_HOME)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ovf_used (ovf_used)
    );

    ipt_free_pick #(.NUM_HOME(NUM_HOME)) u_pick (
        .ovf_used (ovf_used),
        .found    (free_ok),
        .slot     (free_idx)
    );

    ipt_ctrl #(.NUM_HOME(NUM_HOME), .MAX_VISIT(MAX_VISIT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_ready  (lk_ready),
        .lk_pid    (lk_pid),
        .lk_vpn    (lk_vpn),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_frame (rsp_frame),
        .mt_valid  (mt_valid),
        .mt_ready  (mt_ready),
        .mt_op     (mt_op),
        .mt_pid    (mt_pid),
        .mt_vpn    (mt_vpn),
        .mt_frame  (mt_frame),
        .mt_done   (mt_done),
        .mt_err    (mt_err),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .free_ok   (free_ok),
        .free_idx  (free_idx)
    );

endmodule

// File: tb/tb_ipt_xlate.sv
`timescale 1ns/1ps
module tb_ipt_xlate;

    localparam int NH = 4;
    localparam int MV = 4;
    localparam int N  = ipt_pkg::ENTRIES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [7:0]  lk_pid = '0;
    logic [11:0] lk_vpn = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [5:0]  rsp_frame;
    logic        mt_valid = 1'b0;
    logic        mt_ready;
    logic        mt_op = 1'b0;
    logic [7:0]  mt_pid = '0;
    logic [11:0] mt_vpn = '0;
    logic [5:0]  mt_frame = '0;
    logic        mt_done;
    logic        mt_err;

    int checks = 0;
    int fails  = 0;

    int mv [N];
    int mu [N];
    int mc [N];
    int mn [N];
    int mp [N];
    int mg [N];
    int mf [N];

    always #4 clk = ~clk;

    ipt_xlate #(.NUM_HOME(NH), .MAX_VISIT(MV)) dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pid(lk_pid), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
        .mt_valid(mt_valid), .mt_ready(mt_ready), .mt_op(mt_op), .mt_pid(mt_pid),
        .mt_vpn(mt_vpn), .mt_frame(mt_frame), .mt_done(mt_done), .mt_err(mt_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void m_clear();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mu[i] = 0; mc[i] = 0; mn[i] = 0; mp[i] = 0; mg[i] = 0; mf[i] = 0;
        end
    endfunction

    function automatic void m_lookup(input int p, input int v, output int h, output int f, output int k);
        int cur = v % NH;
        int cnt = 1;
        bit fin = 0;
        h = 0; f = 0; k = 0;
        for (int s = 0; s < N + 2 && !fin; s++) begin
            if (mv[cur] != 0 && mp[cur] == p && mg[cur] == v) begin
                h = 1; f = mf[cur]; k = cnt; fin = 1;
            end else if (mc[cur] != 0 && cnt < MV) begin
                cur = mn[cur]; cnt++;
            end else begin
                k = cnt; fin = 1;
            end
        end
    endfunction

    function automatic void m_insert(input int p, input int v, input int fr, output int err, output int k);
        int cur = v % NH;
        int cnt = 1;
        int slot = -1;
        bit fin = 0;
        err = 0; k = 0;
        for (int i = N - 1; i >= NH; i--) if (mu[i] == 0) slot = i;
        for (int s = 0; s < N + 2 && !fin; s++) begin
            if (mv[cur] == 0) begin
                mv[cur] = 1; mu[cur] = 1; mp[cur] = p; mg[cur] = v; mf[cur] = fr;
                k = cnt; fin = 1;
            end else if (mc[cur] != 0 && cnt < MV) begin
                cur = mn[cur]; cnt++;
            end else if (mc[cur] == 0 && cnt < MV && slot >= 0) begin
                mv[slot] = 1; mu[slot] = 1; mc[slot] = 0; mn[slot] = 0;
                mp[slot] = p; mg[slot] = v; mf[slot] = fr;
                mc[cur] = 1; mn[cur] = slot;
                k = cnt + 1; fin = 1;
            end else begin
                err = 1; k = cnt; fin = 1;
            end
        end
    endfunction

    function automatic void m_inval(input int p, input int v, output int k);
        int cur = v % NH;
        int cnt = 1;
        bit fin = 0;
        k = 0;
        for (int s = 0; s < N + 2 && !fin; s++) begin
            if (mv[cur] != 0 && mp[cur] == p && mg[cur] == v) begin
                mv[cur] = 0; k = cnt; fin = 1;
            end else if (mc[cur] != 0 && cnt < MV) begin
                cur = mn[cur]; cnt++;
            end else begin
                k = cnt; fin = 1;
            end
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_clear();
        chk("R1 lk_ready after reset", lk_ready, 1);
        chk("R1 mt_ready after reset", mt_ready, 1);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 mt_done after reset", mt_done, 0);
    endtask

    task automatic lookup(input int p, input int v, input string req);
        int eh, ef, ek, cyc;
        m_lookup(p, v, eh, ef, ek);
        @(negedge clk);
        lk_pid = 8'(p); lk_vpn = 12'(v); lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R6 lookup ready low while busy", lk_ready, 0);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rsp_valid && cyc < 40);
        chk({req, " R4 lookup latency"}, cyc, ek);
        chk({req, " hit flag"}, rsp_hit, eh);
        chk({req, " frame"}, rsp_frame, ef);
        chk("R6 lookup ready back with response", lk_ready, 1);
    endtask

    task automatic maint(input int op, input int p, input int v, input int fr, input string req);
        int eerr, ek, cyc;
        if (op == 0) m_insert(p, v, fr, eerr, ek);
        else begin
            m_inval(p, v, ek);
            eerr = 0;
        end
        @(negedge clk);
        mt_op = op[0]; mt_pid = 8'(p); mt_vpn = 12'(v); mt_frame = 6'(fr); mt_valid = 1'b1;
        @(negedge clk);
        mt_valid = 1'b0;
        chk("R6 maint ready low while busy", mt_ready, 0);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!mt_done && cyc < 40);
        chk({req, " R4 maint latency"}, cyc, ek);
        chk({req, " error flag"}, mt_err, eerr);
        @(negedge clk);
        chk("R4 done is a single pulse", mt_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int cyc, sel, p, v;
        do_reset();
        lookup(42, 0, "R1 empty table");

        maint(0, 42, 0, 1, "R7 home insert");
        maint(0, 42, 1, 0, "R7 home insert");
        maint(0, 42, 6, 3, "R7 home insert");
        lookup(42, 0, "R3 example page 0");
        lookup(42, 6, "R2 row index page 6");
        lookup(42, 3, "R5 invalid row 3");
        lookup(7, 0, "R3 process mismatch");
        lookup(42, 4, "R3 page mismatch same row");

        maint(0, 42, 4, 9, "R8 append first slot");
        maint(0, 7, 8, 10, "R8 append second slot");
        lookup(42, 4, "R8 chained hit");
        lookup(7, 8, "R4 third entry hit");
        maint(1, 42, 0, 0, "R10 invalidate home");
        lookup(42, 4, "R10 behind tombstone");
        lookup(42, 0, "R5 walk to end of chain");
        maint(0, 5, 12, 11, "R7 reuse tombstone");
        lookup(5, 12, "R7 reused entry");
        lookup(7, 8, "R7 link kept");
        maint(0, 1, 16, 12, "R8 append up to limit");
        maint(0, 1, 20, 13, "R9 chain at visit limit");
        lookup(1, 20, "R9 rejected mapping absent");
        maint(1, 9, 9, 0, "R10 invalidate no match");
        maint(0, 2, 1, 14, "R8 last slot");
        maint(0, 2, 5, 15, "R9 no free slot");
        lookup(2, 5, "R9 not stored");
        lookup(2, 1, "R10 unaffected entry");

        do_reset();
        lookup(1, 16, "R1 table cleared");

        @(negedge clk);
        mt_op = 1'b0; mt_pid = 8'd9; mt_vpn = 12'd33; mt_frame = 6'd17; mt_valid = 1'b1;
        lk_pid = 8'd9; lk_vpn = 12'd33; lk_valid = 1'b1;
        #1;
        chk("R6 maintenance taken first", lk_ready, 0);
        begin
            int e1, e2;
            m_insert(9, 33, 17, e1, e2);
        end
        @(negedge clk);
        mt_valid = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!mt_done && cyc < 40);
        chk("R6 priority insert latency", cyc, 1);
        @(negedge clk);
        lk_valid = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!rsp_valid && cyc < 40);
        chk("R6 deferred lookup latency", cyc, 1);
        chk("R6 deferred lookup sees insert", rsp_hit, 1);
        chk("R6 deferred lookup frame", rsp_frame, 17);

        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            sel = int'($urandom % 8);
            p = (($urandom % 3) == 0) ? 7 : 42;
            v = int'($urandom % 14);
            if (sel < 4) lookup(p, v, "R3 random lookup");
            else if (sel < 6) maint(0, p, v, int'($urandom % 64), "R8 random insert");
            else maint(1, p, v, 0, "R10 random invalidate");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule